// File: doc/BRIEF.md
# Programmable FIFO Threshold Flags

This block sits beside a FIFO's storage and turns the FIFO's word count into three active-low level flags: almost-empty, half-full and almost-full. Two offsets set the thresholds: an empty offset (words still held when almost-empty asserts) and a full offset (free places left when almost-full asserts). Both offsets are `OFS_W` bits wide, the address width of the FIFO, so the capacity is `2**OFS_W` words.

A master reset samples two pins. The load pin picks one of two default offset pairs and, together with them, the way the offsets are loaded afterwards. The timing-mode pin picks standard or fall-through counting. In fall-through mode the output register holds one extra word, and every threshold moves up by one. After reset the offsets can be written word-wide over an offset data bus, empty offset first and then full offset. Or they can be shifted in one bit per clock, starting with the low bit of the empty offset and continuing into the full offset. A partial reset clears the flags to their empty pattern and keeps the offsets, the load method and the timing mode.

All logic runs on the write clock, and every flag is registered. A flag therefore reflects the word count and the offsets as they stood one edge earlier.

Top module: `prog_flag_logic`

## Requirements
- R1: While `mrst_n` is low at a clock edge, `ld` = 0 sets both offsets to `DEF_SMALL` (127) and selects word-wide loading, `ld` = 1 sets both to `DEF_LARGE` (1023) and selects bit-serial loading, and the value of `fwft_sel` is kept as the timing mode (1 = fall-through).
- R2: With word-wide loading selected and no reset active, an edge with `ld` = 1 and `wen` = 1 stores `ofs_din` into the empty offset and the next such edge into the full offset, alternating from then on; any reset makes the next write go to the empty offset again.
- R3: With bit-serial loading selected and no reset active, an edge with `sen` = 1 shifts `si` into the offsets: after 2·OFS_W shifts the first bit is bit 0 of the empty offset, bit OFS_W is bit 0 of the full offset, and the last bit is the full offset's top bit.
- R4: `almost_full_n` is 0 one edge after the word count is at least capacity − full offset (standard) or capacity + 1 − full offset (fall-through), and 1 otherwise.
- R5: `almost_empty_n` is 0 one edge after the word count is at most the empty offset (standard) or the empty offset + 1 (fall-through), and 1 otherwise.
- R6: `half_full_n` is 0 one edge after the word count is at least capacity/2 + 1 (standard) or capacity/2 + 2 (fall-through), and 1 otherwise.
- R7: An edge with `prst_n` low and `mrst_n` high leaves the offsets, the load method and the timing mode unchanged and makes the flags read almost-empty 0, half-full 1, almost-full 1 after that edge; a master reset edge gives the same flag pattern.
- R8: Load requests of the method not selected are ignored (`sen` in word-wide mode, `ld` with `wen` in bit-serial mode), as is every load request on an edge where either reset is low.
- R9: A flag computed on the same edge as an offset load uses the offset from before the load; the new offset takes effect on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; all state changes on its rising edge |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| fwft_sel | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| ld | input | 1 | Default/method select at master reset; word-wide load strobe afterwards |
| wen | input | 1 | Write enable qualifying word-wide offset loads |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial offset data bit |
| ofs_din | input | OFS_W | Word-wide offset data |
| word_cnt | input | OFS_W+2 | Words held by the FIFO, including the fall-through output word |
| almost_empty_n | output | 1 | Active-low almost-empty flag |
| almost_full_n | output | 1 | Active-low almost-full flag |
| half_full_n | output | 1 | Active-low half-full flag |

## Verification
Two events can collide on one edge: an offset load and the flag evaluation that reads the same offset, and a reset and a load request. The bench holds the word count just past a threshold and loads a new empty offset on that edge. The flag must keep the old verdict for one edge and change on the next. It also raises load strobes and serial shifts during partial reset and afterwards sweeps the count across every threshold, so that any offset that slipped through shows up as a moved flag edge. A behavioural model in the bench predicts all three flags every cycle.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    typedef enum logic {
        LOAD_WORD   = 1'b0,
        LOAD_SERIAL = 1'b1
    } load_method_e;

endpackage

// File: rtl/pfl_offset_regs.sv
module pfl_offset_regs
    import pfl_pkg::*;
#(
    parameter int OFS_W     = 10,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             ld,
    input  logic             wen,
    input  logic             sen,
    input  logic             si,
    input  logic [OFS_W-1:0] ofs_din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);

    localparam logic [OFS_W-1:0] SMALL_V = DEF_SMALL[OFS_W-1:0];
    localparam logic [OFS_W-1:0] LARGE_V = DEF_LARGE[OFS_W-1:0];

    typedef struct packed {
        logic [OFS_W-1:0] n_ofs;
        logic [OFS_W-1:0] m_ofs;
        load_method_e     method;
        logic             to_full;
    } ofs_state_t;

    ofs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.n_ofs   = ld ? LARGE_V : SMALL_V;
            st_d.m_ofs   = ld ? LARGE_V : SMALL_V;
            st_d.method  = ld ? LOAD_SERIAL : LOAD_WORD;
            st_d.to_full = 1'b0;
        end else if (!prst_n) begin
            st_d.to_full = 1'b0;
        end else if (st_q.method == LOAD_WORD) begin
            if (ld && wen) begin
                if (st_q.to_full) begin
                    st_d.m_ofs = ofs_din;
                end else begin
                    st_d.n_ofs = ofs_din;
                end
                st_d.to_full = ~st_q.to_full;
            end
        end else if (sen) begin
            st_d.n_ofs = {st_q.m_ofs[0], st_q.n_ofs[OFS_W-1:1]};
            st_d.m_ofs = {si, st_q.m_ofs[OFS_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign empty_ofs = st_q.n_ofs;
    assign full_ofs  = st_q.m_ofs;

endmodule

// File: rtl/pfl_flag_eval.sv
module pfl_flag_eval #(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic [OFS_W+1:0] word_cnt,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic             almost_empty_n,
    output logic             almost_full_n,
    output logic             half_full_n
);

    localparam int CNT_W = OFS_W + 2;
    localparam int XW    = CNT_W + 1;
    localparam int DEPTH = 1 << OFS_W;
    localparam int HALF1 = DEPTH / 2 + 1;
    localparam logic [XW-1:0] DEPTH_X = DEPTH[XW-1:0];
    localparam logic [XW-1:0] HALF1_X = HALF1[XW-1:0];

    typedef struct packed {
        logic fwft;
        logic ae_n;
        logic af_n;
        logic hf_n;
    } flag_state_t;

    flag_state_t fs_d, fs_q;

    logic [XW-1:0] cnt_x, n_x, m_x, adj_x;
    logic          ae_hit, af_hit, hf_hit;

    always_comb begin
        cnt_x  = {1'b0, word_cnt};
        n_x    = {{(XW-OFS_W){1'b0}}, empty_ofs};
        m_x    = {{(XW-OFS_W){1'b0}}, full_ofs};
        adj_x  = {{(XW-1){1'b0}}, fs_q.fwft};
        ae_hit = cnt_x <= (n_x + adj_x);
        af_hit = (cnt_x + m_x) >= (DEPTH_X + adj_x);
        hf_hit = cnt_x >= (HALF1_X + adj_x);
    end

    always_comb begin
        fs_d = fs_q;
        if (!mrst_n || !prst_n) begin
            if (!mrst_n) begin
                fs_d.fwft = fwft_sel;
            end
            fs_d.ae_n = 1'b0;
            fs_d.af_n = 1'b1;
            fs_d.hf_n = 1'b1;
        end else begin
            fs_d.ae_n = ~ae_hit;
            fs_d.af_n = ~af_hit;
            fs_d.hf_n = ~hf_hit;
        end
    end

    always_ff @(posedge clk) begin
        fs_q <= fs_d;
    end

    assign almost_empty_n = fs_q.ae_n;
    assign almost_full_n  = fs_q.af_n;
    assign half_full_n    = fs_q.hf_n;

endmodule

// File: rtl/prog_flag_logic.sv
module prog_flag_logic #(
    parameter int OFS_W     = 10,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023
) (
    input  logic             wclk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic             ld,
    input  logic             wen,
    input  logic             sen,
    input  logic             si,
    input  logic [OFS_W-1:0] ofs_din,
    input  logic [OFS_W+1:0] word_cnt,
    output logic             almost_empty_n,
    output logic             almost_full_n,
    output logic             half_full_n
);

    logic [OFS_W-1:0] empty_ofs;
    logic [OFS_W-1:0] full_ofs;

    pfl_offset_regs #(
        .OFS_W    (OFS_W),
        .DEF_SMALL(DEF_SMALL),
        .DEF_LARGE(DEF_LARGE)
    ) u_ofs (
        .clk      (wclk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .ld       (ld),
        .wen      (wen),
        .sen      (sen),
        .si       (si),
        .ofs_din  (ofs_din),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs)
    );

    pfl_flag_eval #(
        .OFS_W(OFS_W)
    ) u_flags (
        .clk           (wclk),
        .mrst_n        (mrst_n),
        .prst_n        (prst_n),
        .fwft_sel      (fwft_sel),
        .word_cnt      (word_cnt),
        .empty_ofs     (empty_ofs),
        .full_ofs      (full_ofs),
        .almost_empty_n(almost_empty_n),
        .almost_full_n (almost_full_n),
        .half_full_n   (half_full_n)
    );

endmodule

// File: rtl/prog_flag_logic_chk.sv
module prog_flag_logic_chk #(
    parameter int OFS_W = 10
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             ld,
    input logic             sen,
    input logic [OFS_W+1:0] word_cnt,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs,
    input logic             almost_empty_n,
    input logic             almost_full_n,
    input logic             half_full_n
);

    localparam int DEPTH = 1 << OFS_W;
    localparam logic [OFS_W+1:0] OVER_FULL = (DEPTH + 1);

    // R4 and R6: a count beyond capacity must report both upper flags
    assert_top_full_R4: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && word_cnt >= OVER_FULL) |=> (!almost_full_n && !half_full_n));

    // R5: an empty FIFO always reads almost-empty and nothing above it
    assert_empty_count_R5: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && word_cnt == '0) |=> (!almost_empty_n && almost_full_n && half_full_n));

    // R7: partial reset forces the empty flag pattern
    assert_prst_flags_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        (!prst_n) |=> (!almost_empty_n && almost_full_n && half_full_n));

    // R7: partial reset keeps the offsets
    assert_prst_keep_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        (!prst_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R8: with no strobe of either method the offsets never move
    assert_no_load_R8: assert property (@(posedge clk) disable iff (!mrst_n)
        (!ld && !sen) |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

bind prog_flag_logic prog_flag_logic_chk #(.OFS_W(OFS_W)) u_chk (
    .clk           (wclk),
    .mrst_n        (mrst_n),
    .prst_n        (prst_n),
    .ld            (ld),
    .sen           (sen),
    .word_cnt      (word_cnt),
    .empty_ofs     (empty_ofs),
    .full_ofs      (full_ofs),
    .almost_empty_n(almost_empty_n),
    .almost_full_n (almost_full_n),
    .half_full_n   (half_full_n)
);

// File: tb/prog_flag_logic_tb.sv
module prog_flag_logic_tb;

    localparam int W     = 10;
    localparam int D     = 1 << W;
    localparam int MASK  = D - 1;

    logic          wclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
    logic          ld = 1'b0, wen = 1'b0, sen = 1'b0, si = 1'b0;
    logic [W-1:0]  ofs_din = '0;
    logic [W+1:0]  word_cnt = '0;
    logic          almost_empty_n, almost_full_n, half_full_n;

    always #5 wclk = ~wclk;

    prog_flag_logic u_dut (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .ld(ld), .wen(wen), .sen(sen), .si(si), .ofs_din(ofs_din),
        .word_cnt(word_cnt), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .half_full_n(half_full_n)
    );

    // behavioural reference state
    int    m_n, m_m, m_fwft, m_serial, m_to_full;
    logic  e_ae, e_af, e_hf;
    int    vectors = 0, fails = 0;
    string phase = "R1";
    bit    done = 0;

    task automatic model_edge();
        int c, adj;
        c   = int'(word_cnt);
        adj = m_fwft;
        if (!mrst_n) begin
            m_fwft = int'(fwft_sel);
            m_n = ld ? 1023 : 127;
            m_m = m_n;
            m_serial = int'(ld);
            m_to_full = 0;
            e_ae = 0; e_af = 1; e_hf = 1;
        end else if (!prst_n) begin
            m_to_full = 0;
            e_ae = 0; e_af = 1; e_hf = 1;
        end else begin
            e_ae = !(c <= m_n + adj);
            e_af = !(c + m_m >= D + adj);
            e_hf = !(c >= D / 2 + 1 + adj);
            if (m_serial == 0) begin
                if (ld && wen) begin
                    if (m_to_full != 0) m_m = int'(ofs_din);
                    else m_n = int'(ofs_din);
                    m_to_full = 1 - m_to_full;
                end
            end else if (sen) begin
                m_n = (m_n >> 1) | ((m_m & 1) << (W - 1));
                m_m = ((m_m >> 1) | (int'(si) << (W - 1))) & MASK;
            end
        end
    endtask

    task automatic step();
        model_edge();
        @(posedge wclk);
        #1;
        vectors++;
        if (almost_empty_n !== e_ae) begin
            fails++;
            $display("FAIL %s/R5 almost_empty_n got %b exp %b (cnt %0d)", phase, almost_empty_n, e_ae, word_cnt);
        end
        if (almost_full_n !== e_af) begin
            fails++;
            $display("FAIL %s/R4 almost_full_n got %b exp %b (cnt %0d)", phase, almost_full_n, e_af, word_cnt);
        end
        if (half_full_n !== e_hf) begin
            fails++;
            $display("FAIL %s/R6 half_full_n got %b exp %b (cnt %0d)", phase, half_full_n, e_hf, word_cnt);
        end
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int c = lo; c <= hi; c++) begin
            word_cnt = (W + 2)'(c);
            step();
        end
    endtask

    task automatic word_load(input int v);
        ld = 1'b1; wen = 1'b1; ofs_din = W'(v);
        step();
        ld = 1'b0; wen = 1'b0;
    endtask

    task automatic serial_word(input int v);
        sen = 1'b1;
        for (int i = 0; i < W; i++) begin
            si = v[i];
            step();
        end
        sen = 1'b0; si = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: small defaults, word-wide method, standard timing
        phase = "R1";
        mrst_n = 1'b0; ld = 1'b0; fwft_sel = 1'b0;
        step(); step();
        mrst_n = 1'b1;
        sweep(0, 2);
        sweep(125, 130);
        sweep(511, 515);
        sweep(894, 899);
        sweep(1023, 1025);

        // R2: word-wide loads alternate empty then full offset
        phase = "R2";
        word_load(40);
        word_load(1000);
        sweep(20, 27);
        sweep(38, 43);

        // R8: serial shifts ignored in word-wide method
        phase = "R8";
        sen = 1'b1; si = 1'b1;
        step(); step(); step(); step(); step();
        sen = 1'b0; si = 1'b0;
        sweep(38, 43);
        sweep(21, 26);

        // R9: load on the same edge as a count past the old threshold
        phase = "R9";
        word_cnt = 41;
        step();
        word_load(50);
        step(); step();
        word_load(30);
        sweep(992, 996);

        // R7: partial reset keeps offsets, resets load pointer, ignores loads
        phase = "R7";
        word_load(45);
        prst_n = 1'b0; ld = 1'b1; wen = 1'b1; ofs_din = 7;
        word_cnt = 600;
        step(); step();
        prst_n = 1'b1; ld = 1'b0; wen = 1'b0;
        sweep(43, 47);
        word_load(60);
        sweep(58, 62);
        sweep(992, 996);

        // R1: large defaults, serial method, fall-through timing
        phase = "R1";
        mrst_n = 1'b0; ld = 1'b1; fwft_sel = 1'b1;
        step(); step();
        mrst_n = 1'b1; ld = 1'b0; fwft_sel = 1'b0;
        sweep(0, 3);
        sweep(511, 515);
        sweep(1022, 1025);

        // R3: serial load, empty offset low bit first, then full offset
        phase = "R3";
        serial_word(5);
        serial_word(900);
        sweep(4, 8);
        sweep(122, 127);
        sweep(512, 515);

        // R8: word-wide strobes ignored in serial method
        phase = "R8";
        word_load(3);
        word_load(700);
        sweep(4, 8);
        sweep(123, 126);

        // R7: partial reset retains fall-through timing and ignores shifts
        phase = "R7";
        prst_n = 1'b0; sen = 1'b1; si = 1'b1;
        step(); step(); step();
        prst_n = 1'b1; sen = 1'b0; si = 1'b0;
        sweep(4, 8);
        sweep(123, 126);
        sweep(512, 515);

        summary();
    end

endmodule